// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns one externally supplied start address into the word address for each beat of a four-beat burst. On a load cycle it captures a base address and the transfer direction. On each following advance cycle it steps a beat counter. The two low address bits of the output are formed from the base and the beat count, either by modulo addition (linear order) or by exclusive-or (interleaved order). A static strap input picks the order. The upper address bits never move during a burst.

A controller with two states keeps track of whether a burst is running. `ST_IDLE` means no burst is active. `ST_BURST` means a burst is active. The transitions are as follows:
- LOAD: `ST_IDLE` to `ST_BURST`, on a load with the select input high.
- RELOAD: `ST_BURST` to `ST_BURST`, on a load with the select input high; the burst restarts at beat 0.
- STEP: `ST_BURST` to `ST_BURST`, on an advance.
- DESELECT: `ST_BURST` to `ST_IDLE`, on a load with the select input low.
- IGNORE: `ST_IDLE` to `ST_IDLE`, on an advance or a deselect.

When the stall input is high, every register holds its value. All outputs are registered state and change one cycle after the rising edge at which they were sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: A cycle with stall=0, advance=0 and sel=1 is a load. After the next edge, addr_out equals addr_in, busy=1 and burst_wr equals wr_in.
- R2: With order_ilv=0 (linear), the low two bits of beat k are (start low bits + k) mod 4.
- R3: With order_ilv=1 (interleaved), the low two bits of beat k are (start low bits) XOR k.
- R4: addr_out bits above bit 1 do not change on any cycle that is not a load.
- R5: An advance after the fourth beat wraps to the first beat address of the burst.
- R6: A cycle with stall=0, advance=0 and sel=0 ends the burst. busy=0 after the next edge, and addr_out holds its value.
- R7: An advance while busy=0 starts nothing. busy stays 0 and addr_out is unchanged.
- R8: wr_in and addr_in are ignored on advance cycles. burst_wr keeps the value latched at the load.
- R9: While stall=1, addr_out, busy and burst_wr hold their values, whatever the other inputs are.
- R10: During reset, addr_out=0, busy=0 and burst_wr=0.
- R11: A load during an active burst restarts the sequence from beat 0 at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | 1 = suspend; all state holds |
| advance | input | 1 | 1 = step the burst, 0 = load or deselect |
| sel | input | 1 | Select qualifier for load cycles |
| wr_in | input | 1 | Direction sampled at load (1 = write) |
| order_ilv | input | 1 | Static strap: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current beat address |
| busy | output | 1 | Burst active |
| burst_wr | output | 1 | Direction latched at the last load |

## Verification
Each result is due one cycle after the stimulus: the inputs sampled at a rising edge appear on addr_out, busy and burst_wr right after that edge. The driver applies inputs at the falling edge. For each driven cycle it pushes exactly one expected item, computed from the requirements. The monitor pops and compares that item 5 ns after the following rising edge, so each comparison lines up with the single register stage between input and output. Stall, deselect and idle-advance cycles push items that expect unchanged outputs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic       advance,
    input  logic       sel,
    input  logic       wr_in,
    output seq_state_e state,
    output logic       do_load,
    output logic       do_step,
    output logic       burst_wr
);
    seq_state_e nxt;

    // state register and latched direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            burst_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (do_load) burst_wr <= wr_in;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!stall && !advance && sel) nxt = ST_BURST;          // LOAD
            end
            ST_BURST: begin
                if (!stall && !advance) nxt = sel ? ST_BURST : ST_IDLE; // RELOAD / DESELECT
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        do_load = !stall && !advance && sel;
        do_step = !stall && advance && (state == ST_BURST);
    end

    // R6
    deselect_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance && !sel) |=> (state == ST_IDLE));

    // R7
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !stall && advance) |=> (state == ST_IDLE));

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance) |=> $stable(burst_wr));
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int BEATS = 4,
    localparam int CW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_load,
    input  logic          do_step,
    output logic [CW-1:0] beat
);
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       beat <= '0;
        else if (do_load) beat <= '0;
        else if (do_step) beat <= beat + 1'b1;
    end

    // R5
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !do_load && beat == LAST) |=> (beat == '0));

    // R11
    beat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (beat == '0));
endmodule

// File: rtl/addr_map.sv
module addr_map #(
    parameter int ADDR_W = 20,
    parameter int BEATS  = 4,
    localparam int CW    = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CW-1:0]     beat,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] base_q;
    logic [CW-1:0]     low_lin;
    logic [CW-1:0]     low_ilv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       base_q <= '0;
        else if (do_load) base_q <= addr_in;
    end

    assign low_lin = base_q[CW-1:0] + beat;

    for (genvar i = 0; i < CW; i++) begin : g_ilv
        assign low_ilv[i] = base_q[i] ^ beat[i];
    end

    assign addr_out = {base_q[ADDR_W-1:CW], (order_ilv ? low_ilv : low_lin)};

    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> (addr_out[ADDR_W-1:CW] == $past(addr_out[ADDR_W-1:CW])));

    // R1
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (addr_out == $past(addr_in)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic              sel,
    input  logic              wr_in,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              busy,
    output logic              burst_wr
);
    localparam int CW = $clog2(BEATS);

    seq_state_e    state;
    logic          do_load;
    logic          do_step;
    logic [CW-1:0] beat;

    burst_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .advance  (advance),
        .sel      (sel),
        .wr_in    (wr_in),
        .state    (state),
        .do_load  (do_load),
        .do_step  (do_step),
        .burst_wr (burst_wr)
    );

    beat_counter #(.BEATS(BEATS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (do_load),
        .do_step (do_step),
        .beat    (beat)
    );

    addr_map #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_load   (do_load),
        .order_ilv (order_ilv),
        .addr_in   (addr_in),
        .beat      (beat),
        .addr_out  (addr_out)
    );

    assign busy = (state == ST_BURST);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(addr_out) && $stable(busy) && $stable(burst_wr)));

    // R7
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && advance) |=> ($stable(addr_out) && !busy));

    // R1
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance && sel) |=> (busy && burst_wr == $past(wr_in)));
endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          advance = 1'b1;
    logic          sel = 1'b0;
    logic          wr_in = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          busy;
    logic          burst_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance), .sel(sel),
        .wr_in(wr_in), .order_ilv(order_ilv), .addr_in(addr_in),
        .addr_out(addr_out), .busy(busy), .burst_wr(burst_wr)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic          b;
        logic          w;
        string         tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic          m_busy;
    logic [AW-1:0] m_base;
    logic [1:0]    m_k;
    logic          m_wr;

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = order_ilv ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic model_reset();
        m_busy = 1'b0; m_base = '0; m_k = 2'd0; m_wr = 1'b0;
    endtask

    task automatic drive(input logic adv, input logic s, input logic w,
                         input logic stl, input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        advance = adv; sel = s; wr_in = w; stall = stl; addr_in = a;
        if (!stl) begin
            if (!adv) begin
                if (s) begin m_busy = 1'b1; m_base = a; m_k = 2'd0; m_wr = w; end
                else   m_busy = 1'b0;
            end else if (m_busy) begin
                m_k = m_k + 2'd1;
            end
        end
        e.a = model_addr(); e.b = m_busy; e.w = m_wr; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (addr_out !== e.a || busy !== e.b || burst_wr !== e.w) begin
                    fails++;
                    $display("FAIL %s: addr=%h busy=%b wr=%b, expected addr=%h busy=%b wr=%b",
                             e.tag, addr_out, busy, burst_wr, e.a, e.b, e.w);
                end
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset(input logic ord);
        @(negedge clk);
        rst_n = 1'b0; order_ilv = ord; advance = 1'b1; sel = 1'b0; stall = 1'b0;
        model_reset();
        #5;
        checks++;
        if (addr_out !== '0 || busy !== 1'b0 || burst_wr !== 1'b0) begin
            fails++;
            $display("FAIL R10: addr=%h busy=%b wr=%b, expected addr=0 busy=0 wr=0",
                     addr_out, busy, burst_wr);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        // linear order
        do_reset(1'b0);
        drive(1, 0, 0, 0, 20'h0, "R7");           // advance while idle
        drive(0, 1, 1, 0, 20'h12345, "R1");       // load, low bits 01
        drive(1, 0, 0, 0, 20'hFFFFF, "R2");       // 10, wr/addr ignored
        drive(1, 1, 0, 0, 20'h00000, "R8");       // 11
        drive(1, 0, 1, 0, 20'h55555, "R4");       // 00 without carry
        drive(1, 0, 0, 0, 20'h0, "R5");           // wrap to 01
        drive(0, 1, 0, 1, 20'hAAAAA, "R9");       // stalled load ignored
        drive(1, 0, 0, 1, 20'h0, "R9");           // stalled advance ignored
        drive(1, 0, 0, 0, 20'h0, "R2");           // 10
        drive(0, 1, 0, 0, 20'hABCD3, "R11");      // reload mid burst, low 11
        drive(1, 0, 1, 0, 20'h0, "R2");           // 00
        drive(1, 0, 1, 0, 20'h0, "R2");           // 01
        drive(1, 0, 0, 0, 20'h0, "R2");           // 10
        drive(0, 0, 1, 0, 20'h77777, "R6");       // deselect
        drive(1, 0, 0, 0, 20'h0, "R7");           // advance while idle
        drive(1, 1, 1, 0, 20'h11111, "R7");
        drive(0, 0, 0, 1, 20'h0, "R9");           // stall while idle
        // interleaved order
        do_reset(1'b1);
        drive(0, 1, 0, 0, 20'h00F02, "R1");       // low 10
        drive(1, 0, 1, 0, 20'h0, "R3");           // 11
        drive(1, 0, 1, 0, 20'h0, "R3");           // 00
        drive(1, 0, 0, 0, 20'h0, "R3");           // 01
        drive(1, 0, 0, 0, 20'h0, "R5");           // wrap to 10
        drive(0, 1, 1, 0, 20'h7FFF1, "R11");      // low 01
        drive(1, 0, 0, 0, 20'h0, "R3");           // 00
        drive(1, 0, 0, 0, 20'h0, "R4");           // 11
        drive(1, 0, 0, 0, 20'h0, "R3");           // 10
        drive(0, 1, 0, 0, 20'hC0003, "R1");       // low 11
        drive(1, 0, 1, 0, 20'h0, "R3");           // 10
        drive(1, 0, 0, 1, 20'hFFFFF, "R9");
        drive(1, 0, 0, 0, 20'h0, "R3");           // 01
        drive(1, 0, 0, 0, 20'h0, "R3");           // 00
        drive(0, 0, 0, 0, 20'h0, "R6");
        drive(1, 0, 0, 0, 20'h0, "R7");
        repeat (3) @(posedge clk);
        report();
    end
endmodule